// File: doc/BRIEF.md
# Programmable Four-Channel Timer Bank

This block holds four independent 16-bit up-counters behind one simple register port. Each counter has its own window in the address space with a count, a mode, a compare and (on the first two channels only) a hold register. A counter advances by one on each pulse of an external prescaler tick while its run bit is set. When a tick carries it onto its compare value, or wraps it from all ones to zero, and the matching event is enabled, the channel latches a flag and drives its interrupt line. It can also restart its count from zero at that point.

Channel 0 is a periodic timer: it keeps its event enables after firing. Channels 1 to 3 are single-shot: firing clears their event enables, so they fire once until software re-arms them. The four interrupt outputs go, in channel order, to lines 9 through 12 of an interrupt controller that sits outside this block. The register port is single-cycle. A write takes effect at the next clock edge. Read data is combinational from the address presented in the same cycle.

Top module: `tmrbank_top`

## Requirements
- R1: Channel n (0 to 3) is selected by address bits [12:11] with all higher address bits zero. In its window the count sits at 0x00, the mode at 0x10, the compare at 0x20 and the hold at 0x30. Any other address reads as zero and a write to it changes nothing.
- R2: After reset every count, mode, compare and hold register reads zero and all interrupt outputs are low.
- R3: Channels 0 and 1 have a 16-bit read/write hold register. Any access to the hold offset of channel 2 or 3 raises `bad_access` in the same cycle. Such a read returns zero and such a write is ignored.
- R4: While mode bit 0 (run) is set, each cycle with `tick` high raises the count by one. With run clear, or with `tick` low, the count does not change.
- R5: A write to the count loads the written value at the next edge. It takes priority over a tick in the same cycle, which is then lost.
- R6: With mode bit 2 (compare enable) set, a tick that brings the count to the compare value sets mode bit 4 (compare flag). With mode bit 3 (overflow enable) set, a tick at count 0xFFFF sets mode bit 5 (overflow flag). `irq[n]` is high exactly while either flag of channel n is set, starting in the cycle after the tick.
- R7: With mode bit 1 (zero return) set, the tick that causes an enabled event leaves the count at zero instead of the incremented value. Without it the count simply moves on.
- R8: Channel 0 keeps its enable bits when it fires and so fires again every period. Channels 1 to 3 clear mode bits 2 and 3 in the cycle they fire.
- R9: A mode write replaces bits 3:0 with the written value and clears each flag bit (4, 5) written as one; flags written as zero are kept. Mode reads return the six bits zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle prescaler pulse shared by all channels |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bad_access | output | 1 | Access to a hold register that does not exist |
| irq | output | 4 | Per-channel interrupt, bit n for channel n |

## Verification
The hardest situation to reach from the ports is a count load colliding with a running tick in one clock cycle. A plain write sequence never overlaps a tick. The bench therefore drives `tick` and a count write in the same cycle on a running channel, and checks that the loaded value appears rather than that value plus one. A second hard case is the firing tick itself. The bench sweeps the compare value over a small range on the periodic and on a single-shot channel, checks the count and the interrupt after every tick, and walks counts to 0xFFFE so that the wrap is reached in two ticks.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;

  // mode register bit positions
  localparam int MB_RUN   = 0;
  localparam int MB_ZRET  = 1;
  localparam int MB_CMPEN = 2;
  localparam int MB_OVFEN = 3;
  localparam int MB_CMPF  = 4;
  localparam int MB_OVFF  = 5;
  localparam int MODE_W   = 6;

  // register selected by address bits [5:4] inside a channel window
  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_MODE  = 2'd1,
    REG_COMP  = 2'd2,
    REG_HOLD  = 2'd3
  } reg_sel_e;

endpackage

// File: rtl/tmrbank_decode.sv
module tmrbank_decode
  import tmrbank_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int NUM_TIMERS  = 4,
  parameter int HOLD_TIMERS = 2,
  parameter int WIN_LSB     = 11
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  output logic                          hit,
  output logic [$clog2(NUM_TIMERS)-1:0] idx,
  output reg_sel_e                      rsel,
  output logic                          bad_access,
  output logic [NUM_TIMERS-1:0]         wr_cnt,
  output logic [NUM_TIMERS-1:0]         wr_mode,
  output logic [NUM_TIMERS-1:0]         wr_comp,
  output logic [NUM_TIMERS-1:0]         wr_hold
);

  localparam int IDX_W = $clog2(NUM_TIMERS);
  localparam int TOP   = WIN_LSB + IDX_W;

  logic upper_ok;
  logic idx_ok;
  logic ofs_ok;
  logic has_hold;

  generate
    if (ADDR_W > TOP) begin : g_upper
      assign upper_ok = (bus_addr[ADDR_W-1:TOP] == '0);
    end else begin : g_noupper
      assign upper_ok = 1'b1;
    end
  endgenerate

  assign idx      = bus_addr[WIN_LSB +: IDX_W];
  assign idx_ok   = ({1'b0, idx} < (IDX_W+1)'(NUM_TIMERS));
  assign has_hold = ({1'b0, idx} < (IDX_W+1)'(HOLD_TIMERS));
  assign ofs_ok   = (bus_addr[WIN_LSB-1:6] == '0) && (bus_addr[3:0] == '0);
  assign rsel     = reg_sel_e'(bus_addr[5:4]);
  assign hit      = bus_sel & upper_ok & idx_ok & ofs_ok;

  assign bad_access = hit & (rsel == REG_HOLD) & ~has_hold;

  generate
    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_strobe
      logic mine;
      assign mine       = hit & bus_wr & (idx == IDX_W'(i));
      assign wr_cnt[i]  = mine & (rsel == REG_COUNT);
      assign wr_mode[i] = mine & (rsel == REG_MODE);
      assign wr_comp[i] = mine & (rsel == REG_COMP);
      if (i < HOLD_TIMERS) begin : g_h
        assign wr_hold[i] = mine & (rsel == REG_HOLD);
      end else begin : g_nh
        assign wr_hold[i] = 1'b0;
      end
    end
  endgenerate

  // R1: one write strobe at most per cycle across all channels and registers
  assert_onehot_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_cnt, wr_mode, wr_comp, wr_hold}));

endmodule

// File: rtl/tmrbank_channel.sv
module tmrbank_channel
  import tmrbank_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter bit HAS_HOLD = 1'b1,
  parameter bit ONE_SHOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_cnt,
  input  logic              wr_mode,
  input  logic              wr_comp,
  input  logic              wr_hold,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [CNT_W-1:0]  comp_q,
  output logic [CNT_W-1:0]  hold_q,
  output logic              irq
);

  logic [CNT_W-1:0]  cnt_d;
  logic [CNT_W-1:0]  inc;
  logic [MODE_W-1:0] mode_d;
  logic              step;
  logic              cmp_hit;
  logic              ovf_hit;
  logic              fire;
  logic              cnt_en;
  logic              mode_en;

  // event detection
  assign inc     = cnt_q + 1'b1;
  assign step    = tick & mode_q[MB_RUN] & ~wr_cnt;
  assign cmp_hit = step & mode_q[MB_CMPEN] & (inc == comp_q);
  assign ovf_hit = step & mode_q[MB_OVFEN] & (&cnt_q);
  assign fire    = cmp_hit | ovf_hit;

  // next state
  always_comb begin
    cnt_d = cnt_q;
    if (wr_cnt) begin
      cnt_d = wdata;
    end else if (step) begin
      cnt_d = (fire && mode_q[MB_ZRET]) ? '0 : inc;
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (wr_mode) begin
      mode_d[MB_OVFEN:MB_RUN] = wdata[MB_OVFEN:MB_RUN];
      mode_d[MB_CMPF] = mode_q[MB_CMPF] & ~wdata[MB_CMPF];
      mode_d[MB_OVFF] = mode_q[MB_OVFF] & ~wdata[MB_OVFF];
    end else if (ONE_SHOT && fire) begin
      mode_d[MB_CMPEN] = 1'b0;
      mode_d[MB_OVFEN] = 1'b0;
    end
    if (cmp_hit) mode_d[MB_CMPF] = 1'b1;
    if (ovf_hit) mode_d[MB_OVFF] = 1'b1;
  end

  assign cnt_en  = wr_cnt | step;
  assign mode_en = wr_mode | fire;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      comp_q <= '0;
    end else if (wr_comp) begin
      comp_q <= wdata;
    end
  end

  generate
    if (HAS_HOLD) begin : g_hold
      logic [CNT_W-1:0] hold_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hold_r <= '0;
        end else if (wr_hold) begin
          hold_r <= wdata;
        end
      end
      assign hold_q = hold_r;
    end else begin : g_nohold
      logic unused_wr_hold;
      assign unused_wr_hold = wr_hold;
      assign hold_q = '0;
    end
  endgenerate

  assign irq = mode_q[MB_CMPF] | mode_q[MB_OVFF];

  // R5: a count write is visible on the next cycle whatever the tick did
  assert_cnt_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wdata)));

  // R4: without a tick or a load the count stays put
  assert_cnt_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt_q));

  // R6: the interrupt only rises after a qualifying event
  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fire));

  generate
    if (ONE_SHOT) begin : g_a_once
      // R8: single-shot channels drop their enables after firing
      assert_single_shot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr_mode) |=> (!mode_q[MB_CMPEN] && !mode_q[MB_OVFEN]));
    end else begin : g_a_per
      // R8: the periodic channel keeps its enables after firing
      assert_periodic_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr_mode) |=> $stable(mode_q[MB_OVFEN:MB_RUN]));
    end
  endgenerate

endmodule

// File: rtl/tmrbank_rdmux.sv
module tmrbank_rdmux
  import tmrbank_pkg::*;
#(
  parameter int NUM_TIMERS = 4,
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 32
) (
  input  logic                                  rd_en,
  input  logic [$clog2(NUM_TIMERS)-1:0]         idx,
  input  reg_sel_e                              rsel,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]      cnt_all,
  input  logic [NUM_TIMERS-1:0][MODE_W-1:0]     mode_all,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]      comp_all,
  input  logic [NUM_TIMERS-1:0][CNT_W-1:0]      hold_all,
  output logic [DATA_W-1:0]                     rdata
);

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (rsel)
        REG_COUNT: rdata[CNT_W-1:0]  = cnt_all[idx];
        REG_MODE:  rdata[MODE_W-1:0] = mode_all[idx];
        REG_COMP:  rdata[CNT_W-1:0]  = comp_all[idx];
        REG_HOLD:  rdata[CNT_W-1:0]  = hold_all[idx];
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/tmrbank_top.sv
module tmrbank_top
  import tmrbank_pkg::*;
#(
  parameter int NUM_TIMERS  = 4,
  parameter int HOLD_TIMERS = 2,
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int WIN_LSB     = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  output logic                  bad_access,
  output logic [NUM_TIMERS-1:0] irq
);

  localparam int IDX_W = $clog2(NUM_TIMERS);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  logic                  hit;
  logic [IDX_W-1:0]      idx;
  reg_sel_e              rsel;
  logic [NUM_TIMERS-1:0] wr_cnt;
  logic [NUM_TIMERS-1:0] wr_mode;
  logic [NUM_TIMERS-1:0] wr_comp;
  logic [NUM_TIMERS-1:0] wr_hold;

  logic [NUM_TIMERS-1:0][CNT_W-1:0]  cnt_all;
  logic [NUM_TIMERS-1:0][MODE_W-1:0] mode_all;
  logic [NUM_TIMERS-1:0][CNT_W-1:0]  comp_all;
  logic [NUM_TIMERS-1:0][CNT_W-1:0]  hold_all;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  tmrbank_decode #(
    .ADDR_W      (ADDR_W),
    .NUM_TIMERS  (NUM_TIMERS),
    .HOLD_TIMERS (HOLD_TIMERS),
    .WIN_LSB     (WIN_LSB)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .hit        (hit),
    .idx        (idx),
    .rsel       (rsel),
    .bad_access (bad_access),
    .wr_cnt     (wr_cnt),
    .wr_mode    (wr_mode),
    .wr_comp    (wr_comp),
    .wr_hold    (wr_hold)
  );

  generate
    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_ch
      tmrbank_channel #(
        .CNT_W    (CNT_W),
        .HAS_HOLD (i < HOLD_TIMERS),
        .ONE_SHOT (i != 0)
      ) u_ch (
        .clk     (clk),
        .rst_n   (rst_n_i),
        .tick    (tick),
        .wr_cnt  (wr_cnt[i]),
        .wr_mode (wr_mode[i]),
        .wr_comp (wr_comp[i]),
        .wr_hold (wr_hold[i]),
        .wdata   (bus_wdata[CNT_W-1:0]),
        .cnt_q   (cnt_all[i]),
        .mode_q  (mode_all[i]),
        .comp_q  (comp_all[i]),
        .hold_q  (hold_all[i]),
        .irq     (irq[i])
      );
    end
  endgenerate

  tmrbank_rdmux #(
    .NUM_TIMERS (NUM_TIMERS),
    .CNT_W      (CNT_W),
    .DATA_W     (DATA_W)
  ) u_rdmux (
    .rd_en    (hit & ~bus_wr & ~bad_access),
    .idx      (idx),
    .rsel     (rsel),
    .cnt_all  (cnt_all),
    .mode_all (mode_all),
    .comp_all (comp_all),
    .hold_all (hold_all),
    .rdata    (bus_rdata)
  );

  // R3: a flagged hold access never returns data
  assert_bad_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    bad_access |-> (bus_rdata == '0));

  // R2: interrupts are quiet in the first cycle after reset release
  assert_reset_quiet_R2: assert property (@(posedge clk)
    $rose(rst_n_i) |-> (irq == '0));

endmodule

// File: tb/tb_tmrbank_top.sv
module tb_tmrbank_top;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        bus_sel;
  logic        bus_wr;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bad_access;
  logic [3:0]  irq;

  int errors = 0;
  int checks = 0;

  tmrbank_top dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bad_access (bad_access),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [15:0] ra(input int t, input int r);
    return 16'(t * 16'h800 + r * 16'h10);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d, output logic bad);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #2;
    d = bus_rdata; bad = bad_access;
    @(negedge clk);
    idle();
  endtask

  task automatic rdchk(input string req, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] d;
    logic b;
    rd(a, d, b);
    chk(req, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic b;
    idle();
    bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: reset state of every register
    chk("R2 irq", {28'd0, irq}, 32'd0);
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 4; r++)
        rdchk("R2 reg", ra(t, r), 32'd0);

    // R1: write/readback sweep of count and compare in every window
    for (int t = 0; t < 4; t++) begin
      wr(ra(t, 0), 32'h1000 + t);
      wr(ra(t, 2), 32'h0A00 + 3 * t);
    end
    for (int t = 0; t < 4; t++) begin
      rdchk("R1 count", ra(t, 0), 32'h1000 + t);
      rdchk("R1 comp", ra(t, 2), 32'h0A00 + 3 * t);
    end
    wr(16'h2000, 32'h1234);
    rdchk("R1 outside", 16'h2000, 32'd0);
    rdchk("R1 keep", ra(0, 0), 32'h1000);
    wr(ra(1, 0) + 16'h8, 32'h4321);
    rdchk("R1 bad ofs", ra(1, 0) + 16'h8, 32'd0);
    rdchk("R1 keep1", ra(1, 0), 32'h1001);

    // R3: hold registers
    wr(ra(0, 3), 32'hBEEF);
    wr(ra(1, 3), 32'h0123);
    rd(ra(0, 3), d, b); chk("R3 hold0", d, 32'hBEEF); chk("R3 ok0", {31'd0, b}, 32'd0);
    rd(ra(1, 3), d, b); chk("R3 hold1", d, 32'h0123);
    for (int t = 2; t < 4; t++) begin
      wr(ra(t, 3), 32'h5555);
      rd(ra(t, 3), d, b);
      chk("R3 nohold data", d, 32'd0);
      chk("R3 nohold flag", {31'd0, b}, 32'd1);
    end

    // R9: mode readback of control bits
    wr(ra(3, 1), 32'hFFC5);
    rdchk("R9 mode", ra(3, 1), 32'h05);
    wr(ra(3, 1), 32'h0);

    // R4: counting with and without run
    wr(ra(3, 0), 32'd0);
    wr(ra(3, 2), 32'hFFF0);
    ticks(3);
    rdchk("R4 stopped", ra(3, 0), 32'd0);
    wr(ra(3, 1), 32'h1);
    for (int n = 1; n <= 6; n++) begin
      ticks(1);
      rdchk("R4 count", ra(3, 0), 32'(n));
    end
    repeat (5) @(negedge clk);
    rdchk("R4 no tick", ra(3, 0), 32'd6);

    // R5: load collides with a tick on a running channel
    wr(ra(0, 1), 32'h1);
    @(negedge clk);
    tick = 1'b1; bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ra(0, 0); bus_wdata = 32'h55;
    @(negedge clk);
    idle();
    rdchk("R5 load wins", ra(0, 0), 32'h55);
    ticks(1);
    rdchk("R5 then counts", ra(0, 0), 32'h56);

    // R6 R7 R8: periodic channel 0, compare sweep
    for (int c = 1; c <= 5; c++) begin
      wr(ra(0, 0), 32'd0);
      wr(ra(0, 2), 32'(c));
      wr(ra(0, 1), 32'h07);
      for (int p = 0; p < 2; p++) begin
        for (int k = 1; k < c; k++) begin
          ticks(1);
          chk("R6 quiet", {31'd0, irq[0]}, 32'd0);
        end
        ticks(1);
        chk("R6 irq0", {31'd0, irq[0]}, 32'd1);
        rdchk("R7 zero", ra(0, 0), 32'd0);
        rdchk("R8 periodic mode", ra(0, 1), 32'h17);
        wr(ra(0, 1), 32'h17);
        chk("R9 clear", {31'd0, irq[0]}, 32'd0);
        rdchk("R9 mode", ra(0, 1), 32'h07);
      end
    end
    wr(ra(0, 1), 32'h0);

    // R8: single-shot channel 1
    wr(ra(1, 0), 32'd0);
    wr(ra(1, 2), 32'd3);
    wr(ra(1, 1), 32'h07);
    ticks(3);
    chk("R6 irq1", {31'd0, irq[1]}, 32'd1);
    rdchk("R8 oneshot mode", ra(1, 1), 32'h13);
    rdchk("R7 zero1", ra(1, 0), 32'd0);
    wr(ra(1, 1), 32'h13);
    chk("R9 clear1", {31'd0, irq[1]}, 32'd0);
    ticks(3);
    chk("R8 no refire", {31'd0, irq[1]}, 32'd0);
    rdchk("R7 plain", ra(1, 0), 32'd3);
    wr(ra(1, 1), 32'h0);

    // R6: compare reached with compare disabled on channel 3
    wr(ra(3, 0), 32'd0);
    wr(ra(3, 2), 32'd2);
    wr(ra(3, 1), 32'h1);
    ticks(2);
    chk("R6 disabled", {31'd0, irq[3]}, 32'd0);
    rdchk("R6 disabled cnt", ra(3, 0), 32'd2);
    wr(ra(3, 1), 32'h0);

    // R6 R8: overflow on single-shot channel 2
    wr(ra(2, 2), 32'h0100);
    wr(ra(2, 0), 32'hFFFE);
    wr(ra(2, 1), 32'h09);
    ticks(1);
    chk("R6 pre-wrap", {31'd0, irq[2]}, 32'd0);
    ticks(1);
    chk("R6 ovf irq2", {31'd0, irq[2]}, 32'd1);
    rdchk("R6 wrap cnt", ra(2, 0), 32'd0);
    rdchk("R8 ovf mode", ra(2, 1), 32'h21);
    wr(ra(2, 1), 32'h20);
    chk("R9 clear2", {31'd0, irq[2]}, 32'd0);

    // R6 R8: overflow on periodic channel 0
    wr(ra(0, 2), 32'h0100);
    wr(ra(0, 0), 32'hFFFF);
    wr(ra(0, 1), 32'h09);
    ticks(1);
    chk("R6 ovf irq0", {28'd0, irq}, 32'h1);
    rdchk("R8 ovf mode0", ra(0, 1), 32'h29);
    wr(ra(0, 1), 32'h20);
    chk("R9 final", {28'd0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule